// File: doc/BRIEF.md
# Frame Writeback Control Register File

This block sits between a host register port and a frame-capture engine that stores composed display lines in memory. Software programs a destination base address, a line pitch in bytes and the frame dimensions, then launches a frame through a control word. The block emits a one-cycle start strobe toward the capture datapath and holds a busy flag until the datapath reports the end of the frame. It counts the lines the datapath has committed to memory, and it raises an interrupt when the engine becomes idle.

Several features live in the control word. An abort ends the frame at once and withdraws the permission to write to memory. An auto-restart option issues a new start strobe at every frame end. A power-down bit controls the line memory. A sticky alignment-error flag records misaligned address or pitch writes. Fixed identification bits let software recognise the block. Register reads are combinational from registered state. Writes take effect on the next clock edge.

Top module: `fwb_ctrl_regs`

## Requirements
- R1: Registers sit at byte offsets 0x00 (base address), 0x04 (pitch), 0x08 (dimensions: width in bits 15:0, height in bits 31:16) and 0x10 (line progress, read-only). The base, pitch and dimension registers read back exactly as written. width_o and height_o follow the dimension fields.
- R2: A base write with bits 1:0 nonzero, or a pitch write with bits 3:0 nonzero, is stored as written. base_addr_o forces bits 1:0 to zero and pitch_o forces bits 3:0 to zero. The write also sets a sticky error flag, read at control bit 16, which only a control write with bit 16 set clears.
- R3: A control write (offset 0x0C) with bit 0 set, bit 14 clear and the engine idle pulses frame_start_o for exactly one cycle after the write edge and sets busy (control bit 1, also wr_enable_o). Bit 0 always reads 0. A start written while busy has no effect.
- R4: When frame_done_i is high while busy and auto-restart is off, busy clears at the next edge.
- R5: When auto-restart (control bit 15) is set and frame_done_i is high while busy, frame_start_o pulses again, busy stays set and progress returns to 0.
- R6: A control write with bit 14 set while busy clears busy and wr_enable_o at the next edge. Afterwards, line_commit_i and frame_done_i do not change progress or busy.
- R7: If interrupt enable (control bit 2) is set when busy clears, irq_o rises at that edge. It stays high until a control write clears bit 2 or a new frame starts.
- R8: Control bits 31:24 read as 0x54 and bits 23:22 read as 01. All other unlisted control bits read 0.
- R9: Control bit 21 is stored and drives mem_pwrdn_o.
- R10: Progress increments on each cycle with line_commit_i high while busy, is cleared when a frame starts, and ignores line_commit_i while idle.
- R11: After reset all registers, busy, irq_o and frame_start_o are 0, and the control word reads 0x5440_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | ADDR_W | Byte offset of the register access |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| frame_start_o | output | 1 | One-cycle frame start strobe |
| wr_enable_o | output | 1 | Memory writes allowed (busy) |
| base_addr_o | output | 32 | Aligned destination base address |
| pitch_o | output | 32 | Aligned line pitch in bytes |
| width_o | output | 16 | Frame width |
| height_o | output | 16 | Frame height |
| mem_pwrdn_o | output | 1 | Line memory power-down |
| line_commit_i | input | 1 | One line committed to memory |
| frame_done_i | input | 1 | Datapath finished the frame |
| irq_o | output | 1 | Idle interrupt |

## Verification
The bench steps through three kinds of frames: a plain single frame with the interrupt enabled, an auto-restarting frame, and a frame stopped by abort. These separate the three ways of leaving busy and show which of them raise the interrupt or a new strobe. Line commits arrive during frames, at a frame end and while idle, which shows whether the counter is tied to busy. Aligned and misaligned address and pitch writes show the difference between the stored value and the masked output, and when the sticky flag sets and clears. A second start written during a frame checks that a start request is ignored while the engine is busy.

// File: rtl/fwb_pkg.sv
package fwb_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned DIM_W = 16;

  localparam logic [4:0] OFF_BASE  = 5'h00;
  localparam logic [4:0] OFF_PITCH = 5'h04;
  localparam logic [4:0] OFF_DIM   = 5'h08;
  localparam logic [4:0] OFF_CTRL  = 5'h0C;
  localparam logic [4:0] OFF_PROG  = 5'h10;

  localparam int unsigned CB_GO      = 0;
  localparam int unsigned CB_BUSY    = 1;
  localparam int unsigned CB_IE      = 2;
  localparam int unsigned CB_ABORT   = 14;
  localparam int unsigned CB_RESTART = 15;
  localparam int unsigned CB_ERR     = 16;
  localparam int unsigned CB_PWRDN   = 21;

  localparam logic [7:0] ID_TAG = 8'h54;
  localparam logic [1:0] ID_REV = 2'b01;
endpackage

// File: rtl/fwb_cfg_regs.sv
module fwb_cfg_regs
  import fwb_pkg::*;
#(
  parameter int unsigned BASE_LSB  = 2,
  parameter int unsigned PITCH_LSB = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             base_we_i,
  input  logic             pitch_we_i,
  input  logic             dim_we_i,
  input  logic             ctrl_we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] base_raw_o,
  output logic [REG_W-1:0] pitch_raw_o,
  output logic [REG_W-1:0] dim_raw_o,
  output logic [REG_W-1:0] base_o,
  output logic [REG_W-1:0] pitch_o,
  output logic             ie_o,
  output logic             restart_en_o,
  output logic             pwrdn_o,
  output logic             err_o
);
  localparam logic [REG_W-1:0] BASE_KEEP  = ~((REG_W'(1) << BASE_LSB) - REG_W'(1));
  localparam logic [REG_W-1:0] PITCH_KEEP = ~((REG_W'(1) << PITCH_LSB) - REG_W'(1));

  logic misalign;
  assign misalign = (base_we_i && |(wdata_i & ~BASE_KEEP)) ||
                    (pitch_we_i && |(wdata_i & ~PITCH_KEEP));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_raw_o   <= '0;
      pitch_raw_o  <= '0;
      dim_raw_o    <= '0;
      ie_o         <= 1'b0;
      restart_en_o <= 1'b0;
      pwrdn_o      <= 1'b0;
      err_o        <= 1'b0;
    end else begin
      if (base_we_i)  base_raw_o  <= wdata_i;
      if (pitch_we_i) pitch_raw_o <= wdata_i;
      if (dim_we_i)   dim_raw_o   <= wdata_i;
      if (ctrl_we_i) begin
        ie_o         <= wdata_i[CB_IE];
        restart_en_o <= wdata_i[CB_RESTART];
        pwrdn_o      <= wdata_i[CB_PWRDN];
      end
      if (misalign) err_o <= 1'b1;
      else if (ctrl_we_i && wdata_i[CB_ERR]) err_o <= 1'b0;
    end
  end

  // raw values stay visible to software; datapath sees aligned ones
  assign base_o  = base_raw_o & BASE_KEEP;
  assign pitch_o = pitch_raw_o & PITCH_KEEP;

  // R2
  misalign_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pitch_we_i && |(wdata_i & ~PITCH_KEEP)) |=> err_o);
  // R2
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !ctrl_we_i) |=> err_o);
endmodule

// File: rtl/fwb_frame_seq.sv
module fwb_frame_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctrl_we_i,
  input  logic go_i,
  input  logic abort_i,
  input  logic ie_wdata_i,
  input  logic ie_q_i,
  input  logic restart_en_i,
  input  logic frame_done_i,
  output logic busy_o,
  output logic frame_start_o,
  output logic irq_o,
  output logic clr_o,
  output logic abort_o
);
  logic start_req, abort_req, done_evt, restart, go_idle, ie_new;

  assign start_req = ctrl_we_i && go_i && !abort_i && !busy_o;
  assign abort_req = ctrl_we_i && abort_i && busy_o;
  assign done_evt  = frame_done_i && busy_o && !abort_req;
  assign restart   = done_evt && restart_en_i;
  assign go_idle   = abort_req || (done_evt && !restart_en_i);
  assign ie_new    = ctrl_we_i ? ie_wdata_i : ie_q_i;
  assign clr_o     = start_req || restart;
  assign abort_o   = abort_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o        <= 1'b0;
      frame_start_o <= 1'b0;
      irq_o         <= 1'b0;
    end else begin
      frame_start_o <= clr_o;
      if (start_req)    busy_o <= 1'b1;
      else if (go_idle) busy_o <= 1'b0;
      if (clr_o)                  irq_o <= 1'b0;
      else if (go_idle && ie_new) irq_o <= 1'b1;
      else if (!ie_new)           irq_o <= 1'b0;
    end
  end

  // R3
  start_sets_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_req |=> (busy_o && frame_start_o));
  // R4
  done_clears_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_evt && !restart_en_i) |=> !busy_o);
  // R6
  abort_clears_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_req |=> !busy_o);
  // R7
  irq_only_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> !busy_o);
endmodule

// File: rtl/fwb_progress.sv
module fwb_progress #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             busy_i,
  input  logic             abort_i,
  input  logic             line_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_o <= '0;
    else if (clr_i)                        cnt_o <= '0;
    else if (line_i && busy_i && !abort_i) cnt_o <= cnt_o + CNT_W'(1);
  end

  // R10
  idle_count_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !clr_i) |=> $stable(cnt_o));
endmodule

// File: rtl/fwb_ctrl_regs.sv
module fwb_ctrl_regs
  import fwb_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned PROG_W    = 16,
  parameter int unsigned BASE_LSB  = 2,
  parameter int unsigned PITCH_LSB = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              frame_start_o,
  output logic              wr_enable_o,
  output logic [REG_W-1:0]  base_addr_o,
  output logic [REG_W-1:0]  pitch_o,
  output logic [DIM_W-1:0]  width_o,
  output logic [DIM_W-1:0]  height_o,
  output logic              mem_pwrdn_o,
  input  logic              line_commit_i,
  input  logic              frame_done_i,
  output logic              irq_o
);
  logic base_we, pitch_we, dim_we, ctrl_we;
  logic [REG_W-1:0] base_raw, pitch_raw, dim_raw, ctrl_rd;
  logic ie_q, restart_q, err_q, busy, clr, abort;
  logic [PROG_W-1:0] prog;

  assign base_we  = reg_wr_i && (reg_addr_i == ADDR_W'(OFF_BASE));
  assign pitch_we = reg_wr_i && (reg_addr_i == ADDR_W'(OFF_PITCH));
  assign dim_we   = reg_wr_i && (reg_addr_i == ADDR_W'(OFF_DIM));
  assign ctrl_we  = reg_wr_i && (reg_addr_i == ADDR_W'(OFF_CTRL));

  fwb_cfg_regs #(.BASE_LSB(BASE_LSB), .PITCH_LSB(PITCH_LSB)) u_cfg (
    .clk_i, .rst_ni,
    .base_we_i(base_we), .pitch_we_i(pitch_we), .dim_we_i(dim_we), .ctrl_we_i(ctrl_we),
    .wdata_i(reg_wdata_i),
    .base_raw_o(base_raw), .pitch_raw_o(pitch_raw), .dim_raw_o(dim_raw),
    .base_o(base_addr_o), .pitch_o(pitch_o),
    .ie_o(ie_q), .restart_en_o(restart_q), .pwrdn_o(mem_pwrdn_o), .err_o(err_q)
  );

  fwb_frame_seq u_seq (
    .clk_i, .rst_ni,
    .ctrl_we_i(ctrl_we), .go_i(reg_wdata_i[CB_GO]), .abort_i(reg_wdata_i[CB_ABORT]),
    .ie_wdata_i(reg_wdata_i[CB_IE]), .ie_q_i(ie_q), .restart_en_i(restart_q),
    .frame_done_i,
    .busy_o(busy), .frame_start_o, .irq_o, .clr_o(clr), .abort_o(abort)
  );

  fwb_progress #(.CNT_W(PROG_W)) u_prog (
    .clk_i, .rst_ni,
    .clr_i(clr), .busy_i(busy), .abort_i(abort), .line_i(line_commit_i),
    .cnt_o(prog)
  );

  assign wr_enable_o = busy;
  assign width_o     = dim_raw[DIM_W-1:0];
  assign height_o    = dim_raw[2*DIM_W-1:DIM_W];

  always_comb begin
    ctrl_rd             = '0;
    ctrl_rd[31:24]      = ID_TAG;
    ctrl_rd[23:22]      = ID_REV;
    ctrl_rd[CB_PWRDN]   = mem_pwrdn_o;
    ctrl_rd[CB_ERR]     = err_q;
    ctrl_rd[CB_RESTART] = restart_q;
    ctrl_rd[CB_IE]      = ie_q;
    ctrl_rd[CB_BUSY]    = busy;
  end

  always_comb begin
    unique case (reg_addr_i)
      ADDR_W'(OFF_BASE):  reg_rdata_o = base_raw;
      ADDR_W'(OFF_PITCH): reg_rdata_o = pitch_raw;
      ADDR_W'(OFF_DIM):   reg_rdata_o = dim_raw;
      ADDR_W'(OFF_CTRL):  reg_rdata_o = ctrl_rd;
      ADDR_W'(OFF_PROG):  reg_rdata_o = REG_W'(prog);
      default:            reg_rdata_o = '0;
    endcase
  end

  // R8
  id_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_W'(OFF_CTRL)) |-> (reg_rdata_o[31:22] == {ID_TAG, ID_REV}));
endmodule

// File: tb/fwb_ctrl_regs_test.sv
module fwb_ctrl_regs_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic        line = 1'b0;
  logic        done = 1'b0;
  logic [31:0] rdata, base_o, pitch_o;
  logic [15:0] width_o, height_o;
  logic        start_o, wen_o, pd_o, irq_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fwb_ctrl_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .frame_start_o(start_o), .wr_enable_o(wen_o),
    .base_addr_o(base_o), .pitch_o(pitch_o), .width_o(width_o), .height_o(height_o),
    .mem_pwrdn_o(pd_o), .line_commit_i(line), .frame_done_i(done), .irq_o(irq_o)
  );

  // reference model
  logic [31:0] m_base = 0, m_pitch = 0, m_dim = 0;
  bit m_ie = 0, m_rs = 0, m_pd = 0, m_err = 0, m_busy = 0, m_irq = 0, m_start = 0;
  int m_prog = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      bit wc, sreq, areq, dev, rs, ie_new, idle, ns;
      wc     = wr && addr == 5'h0C;
      sreq   = wc && wdata[0] && !wdata[14] && !m_busy;
      areq   = wc && wdata[14] && m_busy;
      dev    = done && m_busy && !areq;
      rs     = dev && m_rs;
      ie_new = wc ? wdata[2] : m_ie;
      idle   = areq || (dev && !m_rs);
      ns     = sreq || rs;
      if (ns) m_prog = 0;
      else if (line && m_busy && !areq) m_prog = (m_prog + 1) % 65536;
      if (ns) m_irq = 0;
      else if (idle && ie_new) m_irq = 1;
      else if (!ie_new) m_irq = 0;
      if (sreq) m_busy = 1;
      else if (idle) m_busy = 0;
      m_start = ns;
      if (wr && addr == 5'h00) begin m_base = wdata; if (wdata[1:0] != 0) m_err = 1; end
      if (wr && addr == 5'h04) begin m_pitch = wdata; if (wdata[3:0] != 0) m_err = 1; end
      if (wr && addr == 5'h08) m_dim = wdata;
      if (wc) begin
        m_ie = wdata[2]; m_rs = wdata[15]; m_pd = wdata[21];
        if (wdata[16]) m_err = 0;
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [4:0] a);
    case (a)
      5'h00: return m_base;
      5'h04: return m_pitch;
      5'h08: return m_dim;
      5'h0C: return 32'h5440_0000 | (32'(m_pd) << 21) | (32'(m_err) << 16) |
                    (32'(m_rs) << 15) | (32'(m_ie) << 2) | (32'(m_busy) << 1);
      5'h10: return 32'(m_prog);
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n && !finished) begin
      chk("R3 R5 frame_start_o", 32'(start_o), 32'(m_start));
      chk("R3 R4 R6 wr_enable_o", 32'(wen_o), 32'(m_busy));
      chk("R7 irq_o", 32'(irq_o), 32'(m_irq));
      chk("R9 mem_pwrdn_o", 32'(pd_o), 32'(m_pd));
      chk("R2 base_addr_o", base_o, m_base & 32'hFFFF_FFFC);
      chk("R2 pitch_o", pitch_o, m_pitch & 32'hFFFF_FFF0);
      chk("R1 width_o", 32'(width_o), 32'(m_dim[15:0]));
      chk("R1 height_o", 32'(height_o), 32'(m_dim[31:16]));
      chk("R1 R8 R10 reg_rdata_o", rdata, m_read(addr));
    end
  end

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
    @(negedge clk); addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic pulse_line(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); line = 1'b1;
    end
    @(negedge clk); line = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 R8
    rd_chk("R11 R8 ctrl after reset", 5'h0C, 32'h5440_0000);
    rd_chk("R11 progress after reset", 5'h10, 32'h0);
    chk("R11 irq after reset", 32'(irq_o), 32'h0);

    // R1
    wr_reg(5'h00, 32'h1000_0000);
    wr_reg(5'h04, 32'h0000_1400);
    wr_reg(5'h08, {16'd480, 16'd640});
    rd_chk("R1 base readback", 5'h00, 32'h1000_0000);
    rd_chk("R1 dim readback", 5'h08, 32'h01E0_0280);
    chk("R1 width_o", 32'(width_o), 32'd640);
    rd_chk("R2 no error on aligned", 5'h0C, 32'h5440_0000);

    // R2
    wr_reg(5'h00, 32'h1000_0003);
    rd_chk("R2 raw misaligned base", 5'h00, 32'h1000_0003);
    chk("R2 masked base", base_o, 32'h1000_0000);
    rd_chk("R2 sticky flag set", 5'h0C, 32'h5441_0000);
    wr_reg(5'h04, 32'h0000_1408);
    chk("R2 masked pitch", pitch_o, 32'h0000_1400);
    wr_reg(5'h0C, 32'h0001_0000);
    rd_chk("R2 flag cleared", 5'h0C, 32'h5440_0000);

    // R3 R10 R4 R7
    wr_reg(5'h0C, 32'h0000_0005);
    rd_chk("R3 busy and go reads 0", 5'h0C, 32'h5440_0006);
    pulse_line(3);
    rd_chk("R10 progress counts", 5'h10, 32'd3);
    wr_reg(5'h0C, 32'h0000_0005);  // start while busy: ignored
    chk("R3 no strobe while busy", 32'(start_o), 32'h0);
    rd_chk("R3 progress kept", 5'h10, 32'd3);
    pulse_done();
    chk("R4 busy cleared", 32'(wen_o), 32'h0);
    chk("R7 irq raised", 32'(irq_o), 32'h1);
    pulse_line(2);
    rd_chk("R10 idle lines ignored", 5'h10, 32'd3);
    repeat (3) @(negedge clk);
    chk("R7 irq held", 32'(irq_o), 32'h1);
    wr_reg(5'h0C, 32'h0000_0000);
    chk("R7 irq acked", 32'(irq_o), 32'h0);

    // R5
    wr_reg(5'h0C, 32'h0000_8005);
    pulse_line(4);
    @(negedge clk); done = 1'b1; line = 1'b1;
    @(negedge clk); done = 1'b0; line = 1'b0;
    chk("R5 busy stays", 32'(wen_o), 32'h1);
    chk("R5 no irq on restart", 32'(irq_o), 32'h0);
    rd_chk("R5 progress cleared", 5'h10, 32'h0);
    pulse_line(2);

    // R6
    wr_reg(5'h0C, 32'h0000_4004);
    chk("R6 wr_enable dropped", 32'(wen_o), 32'h0);
    chk("R7 irq after abort", 32'(irq_o), 32'h1);
    pulse_line(2);
    pulse_done();
    rd_chk("R6 progress frozen", 5'h10, 32'd2);
    chk("R6 still idle", 32'(wen_o), 32'h0);

    // new frame clears irq
    wr_reg(5'h0C, 32'h0000_0005);
    chk("R7 irq cleared by start", 32'(irq_o), 32'h0);
    rd_chk("R10 progress cleared by start", 5'h10, 32'h0);
    pulse_done();

    // R9
    wr_reg(5'h0C, 32'h0020_0000);
    chk("R9 power-down", 32'(pd_o), 32'h1);
    rd_chk("R9 readback", 5'h0C, 32'h5460_0000);
    rd_chk("R1 unmapped reads zero", 5'h14, 32'h0);
    wr_reg(5'h10, 32'hFFFF_FFFF);
    rd_chk("R1 progress read-only", 5'h10, 32'h0);

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule